// File: doc/BRIEF.md
# Three-Level Stacked-Carrier PWM Gate Sequencer

This block drives the six power switches of a single-phase, three-level, voltage-doubling inverter leg. A phase accumulator steps through a sine table. The table value is scaled by a modulation index, and the result is compared against two phase-locked triangular carriers and against zero. One carrier covers the positive half of the range and the other the negative half. The three comparison bits pick one of four legal switch patterns. A small state machine holds the chosen pattern. Three dead-time sequencers, one per complementary switch pair, turn the pattern into gate outputs. No pair ever conducts on both sides, and every turn-on is delayed.

Named states of the pattern machine:
- `ST_OFF` (disabled)
- `ST_M1` (+2 level)
- `ST_M2` (zero, positive half)
- `ST_M3` (zero, negative half)
- `ST_M4` (-2 level)

Transitions of the pattern machine:
- enable rise: `ST_OFF`→`ST_M3`. The held reference is 0 at start.
- positive half-cycle: `ST_M1`↔`ST_M2`.
- negative half-cycle: `ST_M3`↔`ST_M4`.
- zero crossings: between the two families.
- any state → `ST_OFF` when enable is low.

Named states of each pair sequencer:
- `DT_OFF`
- `DT_GAP` (both switches off, counting)
- `DT_HI`
- `DT_LO`

Transitions of each pair sequencer:
- `DT_OFF`→`DT_GAP` on activation.
- `DT_HI`/`DT_LO`→`DT_GAP` when the command reverses.
- `DT_GAP`→`DT_HI`/`DT_LO` after the dead time.
- anything → `DT_OFF` when inactive.

With a 50 MHz clock, `CAR_TOP` = 833 gives a carrier near 30 kHz. A tuning word of 4295 gives a 50 Hz reference.

Top module: `tl_spwm_gate`

## Requirements
- R1: In reset, and on the first clock edge after `en_i` is sampled low, all six bits of `gate_o` are 0 and `mode_o` is 0.
- R2: A single counter runs while enabled.
  - It starts at 0, counts up by one per clock to `CAR_TOP`, then counts down to 0, and repeats with a period of 2·`CAR_TOP` clocks.
  - The upper carrier equals the count. The lower carrier equals the count minus `CAR_TOP`.
- R3: The reference comes from a 32-bit phase that is 0 on the first enabled clock and grows by `ftw_i` each clock.
  - The top 8 phase bits form an index k. Let q = k mod 128 and p = q·(128−q). The sine value is s = ⌊508·p/(20480−p)⌋, negated when k ≥ 128.
  - The reference is ⌊s·`mod_idx_i`·`CAR_TOP`/32768⌋, with flooring toward minus infinity.
- R4: The reference used for comparison is held. It is reloaded from R3 only on clocks where the carrier count is 0 or `CAR_TOP`. It is 0 while disabled.
- R5: Three comparison bits are formed from the held reference.
  - A is set when the held reference exceeds the upper carrier. B is set when it exceeds the lower carrier. C is set when it exceeds zero.
  - The S1 command is A OR (B AND NOT C). The S4 command is C.
  - The pattern register takes M1 (S1,S4 = 1,1), M2 (0,1), M3 (1,0) or M4 (0,0) on the next clock. `mode_o` encodes M1..M4 as 0..3.
- R6: While the held reference is positive, the next pattern is M1 or M2. Otherwise it is M3 or M4.
- R7: `gate_o[2]` (S3) always equals `gate_o[0]` (S1), and `gate_o[4]` (S5) always equals `gate_o[1]` (S2).
- R8: Within each pair (S1/S2 on bits 0/1, S3/S5 on bits 2/4, S4/S6 on bits 3/5), the two gates are never both 1.
- R9: Dead time follows these rules:
  - A command reversal turns the conducting switch off on the next clock.
  - A switch turns on only after its pair has been fully off for `DEAD_CYC` consecutive clocks with an unchanged command.
  - A reversal during that gap restarts the count, so a command shorter than the gap produces no pulse.
  - The first turn-on after enable also waits the gap.
- R10: Whenever every pair has exactly one switch on, `gate_o` (bit 5 = S6 … bit 0 = S1) is one of 6'b001101 (M1), 6'b011010 (M2), 6'b100101 (M3) or 6'b110010 (M4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all gates off and rewinds phase and carrier |
| mod_idx_i | input | 8 | Modulation index, 0..255 |
| ftw_i | input | 32 | Reference phase increment per clock |
| gate_o | output | 6 | Gate drives, bit i drives switch i+1 |
| mode_o | output | 2 | Commanded pattern, M1..M4 as 0..3 |

## Verification
The hardest case is a command pulse shorter than the dead time. It only appears when the held reference sits within a few counts of a carrier extreme. That needs a high modulation index near the reference peaks, together with a carrier short enough for a crossing to land one or two clocks from a turning point. The bench builds a small carrier of 12 counts with a 3-clock dead time and sweeps full, half, low and zero index over whole reference periods. It also includes a fast-phase run and mid-run enable drops. It steps an arithmetic model of the counter, the phase, the held reference, the pattern and each pair's gap every clock, and compares `gate_o` and `mode_o` cycle by cycle. This exercises both the swallowed-pulse path and the exact-zero reference at the half-cycle boundaries.

// File: rtl/tl_spwm_pkg.sv
package tl_spwm_pkg;

    // Pattern register states: disabled plus the four legal switch patterns
    typedef enum logic [2:0] {
        ST_OFF,
        ST_M1,
        ST_M2,
        ST_M3,
        ST_M4
    } mode_st_e;

    // Complementary pair sequencer states
    typedef enum logic [1:0] {
        DT_OFF,
        DT_HI,
        DT_LO,
        DT_GAP
    } dt_st_e;

    localparam int IDX_W    = 8;
    localparam int TAB_N    = 1 << IDX_W;
    localparam int TAB_HALF = TAB_N / 2;
    localparam int SINE_AMP = 127;
    localparam int MI_W     = 8;
    localparam int SCALE_SH = 15;

    // Rational sine approximation over one half period, odd symmetry after it
    function automatic int sine_val(input int k);
        int q;
        int p;
        int s;
        q = k % TAB_HALF;
        p = q * (TAB_HALF - q);
        s = (4 * SINE_AMP * p) / ((5 * TAB_HALF * TAB_HALF) / 4 - p);
        if (k >= TAB_HALF) begin
            s = -s;
        end
        return s;
    endfunction

endpackage

// File: rtl/tl_carrier.sv
module tl_carrier #(
    parameter int CAR_TOP = 833,
    parameter int CW      = $clog2(CAR_TOP + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    output logic [CW-1:0] cnt_o,
    output logic          turn_o
);

    localparam logic [CW-1:0] TOP_V = CW'(CAR_TOP);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          up_q;

    // One up/down counter serves both stacked carriers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (!en_i) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            cnt_q <= cnt_q + ONE_V;
            up_q  <= (cnt_q + ONE_V) != TOP_V;
        end else begin
            cnt_q <= cnt_q - ONE_V;
            up_q  <= (cnt_q - ONE_V) == '0;
        end
    end

    assign cnt_o  = cnt_q;
    assign turn_o = (cnt_q == '0) || (cnt_q == TOP_V);

    p_cnt_range_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cnt_q) <= CAR_TOP);

    p_cnt_step_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> ((int'(cnt_q) - int'($past(cnt_q)) == 1) ||
                  (int'($past(cnt_q)) - int'(cnt_q) == 1)));

endmodule

// File: rtl/tl_ref_gen.sv
module tl_ref_gen
    import tl_spwm_pkg::*;
#(
    parameter int PH_W    = 32,
    parameter int CAR_TOP = 833,
    parameter int RW      = $clog2(CAR_TOP + 1) + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 load_i,
    input  logic [PH_W-1:0]      ftw_i,
    input  logic [MI_W-1:0]      mi_i,
    output logic signed [RW-1:0] ref_o
);

    logic [PH_W-1:0]        phase_q;
    logic signed [7:0]      sine_tab [TAB_N];
    logic signed [7:0]      sine_sel;
    logic signed [RW-1:0]   ref_now;
    logic signed [RW-1:0]   ref_hold_q;
    int                     prod;

    // Table computed at elaboration from the rational approximation
    for (genvar g = 0; g < TAB_N; g++) begin : g_tab
        assign sine_tab[g] = 8'(sine_val(g));
    end

    assign sine_sel = sine_tab[phase_q[PH_W-1 -: IDX_W]];

    always_comb begin
        prod    = int'(sine_sel) * int'(mi_i) * CAR_TOP;
        ref_now = RW'(prod >>> SCALE_SH);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q    <= '0;
            ref_hold_q <= '0;
        end else if (!en_i) begin
            phase_q    <= '0;
            ref_hold_q <= '0;
        end else begin
            phase_q <= phase_q + ftw_i;
            if (load_i) begin
                ref_hold_q <= ref_now;
            end
        end
    end

    assign ref_o = ref_hold_q;

    p_hold_stable_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !load_i) |=> $stable(ref_hold_q));

    p_hold_range_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(ref_hold_q) <= CAR_TOP) && (int'(ref_hold_q) >= -CAR_TOP));

endmodule

// File: rtl/tl_mode_fsm.sv
module tl_mode_fsm
    import tl_spwm_pkg::*;
#(
    parameter int CAR_TOP = 833,
    parameter int CW      = $clog2(CAR_TOP + 1),
    parameter int RW      = CW + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic signed [RW-1:0] ref_i,
    output logic                 s1_cmd_o,
    output logic                 s4_cmd_o,
    output logic                 active_o,
    output logic [1:0]           mode_o
);

    mode_st_e state_q;
    mode_st_e state_d;
    logic     cmp_a;
    logic     cmp_b;
    logic     cmp_c;
    logic     want_s1;

    // Stacked carrier comparison: upper, lower and zero thresholds
    always_comb begin
        cmp_a   = int'(ref_i) > int'(cnt_i);
        cmp_b   = int'(ref_i) > (int'(cnt_i) - CAR_TOP);
        cmp_c   = int'(ref_i) > 0;
        want_s1 = cmp_a || (cmp_b && !cmp_c);
        if (!en_i) begin
            state_d = ST_OFF;
        end else if (want_s1) begin
            state_d = cmp_c ? ST_M1 : ST_M3;
        end else begin
            state_d = cmp_c ? ST_M2 : ST_M4;
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from the held pattern
    always_comb begin
        unique case (state_q)
            ST_M1: begin
                s1_cmd_o = 1'b1;
                s4_cmd_o = 1'b1;
                active_o = 1'b1;
                mode_o   = 2'd0;
            end
            ST_M2: begin
                s1_cmd_o = 1'b0;
                s4_cmd_o = 1'b1;
                active_o = 1'b1;
                mode_o   = 2'd1;
            end
            ST_M3: begin
                s1_cmd_o = 1'b1;
                s4_cmd_o = 1'b0;
                active_o = 1'b1;
                mode_o   = 2'd2;
            end
            ST_M4: begin
                s1_cmd_o = 1'b0;
                s4_cmd_o = 1'b0;
                active_o = 1'b1;
                mode_o   = 2'd3;
            end
            default: begin
                s1_cmd_o = 1'b0;
                s4_cmd_o = 1'b0;
                active_o = 1'b0;
                mode_o   = 2'd0;
            end
        endcase
    end

    p_off_when_idle_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (state_q == ST_OFF));

    p_pos_family_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (int'(ref_i) > 0)) |=> (state_q == ST_M1 || state_q == ST_M2));

    p_neg_family_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (int'(ref_i) <= 0)) |=> (state_q == ST_M3 || state_q == ST_M4));

endmodule

// File: rtl/tl_dead_pair.sv
module tl_dead_pair
    import tl_spwm_pkg::*;
#(
    parameter int DEAD_CYC = 16,
    parameter int DW       = $clog2(DEAD_CYC + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic act_i,
    input  logic want_i,
    output logic hi_o,
    output logic lo_o
);

    localparam logic [DW-1:0] LAST_V = DW'(DEAD_CYC - 1);
    localparam logic [DW-1:0] SAT_V  = DW'(DEAD_CYC);

    dt_st_e      st_q;
    logic [DW-1:0] gap_q;
    logic        tgt_q;
    logic [DW-1:0] off_run_q;

    // State register with gap counter and pending target
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= DT_OFF;
            gap_q <= '0;
            tgt_q <= 1'b0;
        end else if (!act_i) begin
            st_q <= DT_OFF;
        end else begin
            unique case (st_q)
                DT_OFF: begin
                    st_q  <= DT_GAP;
                    gap_q <= '0;
                    tgt_q <= want_i;
                end
                DT_HI: begin
                    if (!want_i) begin
                        st_q  <= DT_GAP;
                        gap_q <= '0;
                        tgt_q <= 1'b0;
                    end
                end
                DT_LO: begin
                    if (want_i) begin
                        st_q  <= DT_GAP;
                        gap_q <= '0;
                        tgt_q <= 1'b1;
                    end
                end
                DT_GAP: begin
                    if (want_i != tgt_q) begin
                        tgt_q <= want_i;
                        gap_q <= '0;
                    end else if (gap_q == LAST_V) begin
                        st_q <= tgt_q ? DT_HI : DT_LO;
                    end else begin
                        gap_q <= gap_q + DW'(1);
                    end
                end
                default: st_q <= DT_OFF;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            DT_HI: begin
                hi_o = 1'b1;
                lo_o = 1'b0;
            end
            DT_LO: begin
                hi_o = 1'b0;
                lo_o = 1'b1;
            end
            default: begin
                hi_o = 1'b0;
                lo_o = 1'b0;
            end
        endcase
    end

    // Independent watch of how long the pair has been fully off
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            off_run_q <= '0;
        end else if (hi_o || lo_o) begin
            off_run_q <= '0;
        end else if (off_run_q != SAT_V) begin
            off_run_q <= off_run_q + DW'(1);
        end
    end

    p_dead_hi_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hi_o) |-> (off_run_q == SAT_V));

    p_dead_lo_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lo_o) |-> (off_run_q == SAT_V));

endmodule

// File: rtl/tl_spwm_gate.sv
module tl_spwm_gate
    import tl_spwm_pkg::*;
#(
    parameter int PH_W     = 32,
    parameter int CAR_TOP  = 833,
    parameter int DEAD_CYC = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic [7:0]      mod_idx_i,
    input  logic [PH_W-1:0] ftw_i,
    output logic [5:0]      gate_o,
    output logic [1:0]      mode_o
);

    localparam int CW     = $clog2(CAR_TOP + 1);
    localparam int RW     = CW + 1;
    localparam int N_PAIR = 3;

    logic [CW-1:0]        car_cnt;
    logic                 car_turn;
    logic signed [RW-1:0] ref_held;
    logic                 s1_cmd;
    logic                 s4_cmd;
    logic                 pat_active;
    logic                 pair_act;
    logic [N_PAIR-1:0]    pair_hi;
    logic [N_PAIR-1:0]    pair_lo;

    tl_carrier #(
        .CAR_TOP(CAR_TOP),
        .CW     (CW)
    ) u_carrier (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .cnt_o (car_cnt),
        .turn_o(car_turn)
    );

    tl_ref_gen #(
        .PH_W   (PH_W),
        .CAR_TOP(CAR_TOP),
        .RW     (RW)
    ) u_ref (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .load_i(car_turn),
        .ftw_i (ftw_i),
        .mi_i  (mod_idx_i),
        .ref_o (ref_held)
    );

    tl_mode_fsm #(
        .CAR_TOP(CAR_TOP),
        .CW     (CW),
        .RW     (RW)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .cnt_i   (car_cnt),
        .ref_i   (ref_held),
        .s1_cmd_o(s1_cmd),
        .s4_cmd_o(s4_cmd),
        .active_o(pat_active),
        .mode_o  (mode_o)
    );

    assign pair_act = en_i && pat_active;

    // Pairs 0 and 1 follow the S1 command, pair 2 follows the S4 command
    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        tl_dead_pair #(
            .DEAD_CYC(DEAD_CYC)
        ) u_pair (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .act_i (pair_act),
            .want_i((p == 2) ? s4_cmd : s1_cmd),
            .hi_o  (pair_hi[p]),
            .lo_o  (pair_lo[p])
        );
    end

    assign gate_o = {pair_lo[2], pair_lo[1], pair_hi[2], pair_hi[1], pair_lo[0], pair_hi[0]};

    p_idle_zero_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ((gate_o == 6'b0) && (mode_o == 2'd0)));

    p_mirror_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_o[2] == gate_o[0]) && (gate_o[4] == gate_o[1]));

    p_pair_excl_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[4]) && !(gate_o[3] && gate_o[5]));

endmodule

// File: tb/test_tl_spwm_gate.sv
module test_tl_spwm_gate;

    localparam int TOP  = 12;
    localparam int DEAD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  mi = 8'd0;
    logic [31:0] ftw = 32'd0;
    logic [5:0]  gate;
    logic [1:0]  mode;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Arithmetic model state
    int          m_cnt;
    bit          m_up;
    logic [31:0] m_ph;
    int          m_ref;
    int          m_mode;
    int          m_st [3];
    int          m_c [3];
    bit          m_t [3];
    int          ref_prev = 0;

    always #10 clk = ~clk;

    tl_spwm_gate #(
        .PH_W    (32),
        .CAR_TOP (TOP),
        .DEAD_CYC(DEAD)
    ) i_tl_spwm_gate (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .en_i     (en),
        .mod_idx_i(mi),
        .ftw_i    (ftw),
        .gate_o   (gate),
        .mode_o   (mode)
    );

    function automatic int refval(input logic [31:0] ph, input int m);
        int k;
        int q;
        int p;
        int s;
        k = int'(ph[31:24]);
        q = k % 128;
        p = q * (128 - q);
        s = (508 * p) / (20480 - p);
        if (k >= 128) s = -s;
        return (s * m * TOP) >>> 15;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Model of R2 to R5 and R9, stepped on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        int a;
        int b;
        int cc;
        bit s1;
        bit w;
        if (!rst_n) begin
            m_cnt <= 0; m_up <= 1'b1; m_ph <= '0; m_ref <= 0; m_mode <= -1;
            for (int p = 0; p < 3; p++) begin
                m_st[p] <= 0; m_c[p] <= 0; m_t[p] <= 1'b0;
            end
        end else if (!en) begin
            m_cnt <= 0; m_up <= 1'b1; m_ph <= '0; m_ref <= 0; m_mode <= -1;
            for (int p = 0; p < 3; p++) m_st[p] <= 0;
        end else begin
            if (m_up) begin
                m_cnt <= m_cnt + 1;
                m_up  <= (m_cnt + 1) != TOP;
            end else begin
                m_cnt <= m_cnt - 1;
                m_up  <= (m_cnt - 1) == 0;
            end
            m_ph <= m_ph + ftw;
            if (m_cnt == 0 || m_cnt == TOP) m_ref <= refval(m_ph, int'(mi));
            a  = (m_ref > m_cnt) ? 1 : 0;
            b  = (m_ref > m_cnt - TOP) ? 1 : 0;
            cc = (m_ref > 0) ? 1 : 0;
            s1 = (a != 0) || ((b != 0) && (cc == 0));
            m_mode <= s1 ? ((cc != 0) ? 0 : 2) : ((cc != 0) ? 1 : 3);
            for (int p = 0; p < 3; p++) begin
                w = (p == 2) ? (m_mode == 0 || m_mode == 1) : (m_mode == 0 || m_mode == 2);
                if (m_mode < 0) begin
                    m_st[p] <= 0;
                end else begin
                    case (m_st[p])
                        0: begin m_st[p] <= 3; m_c[p] <= 0; m_t[p] <= w; end
                        1: if (!w) begin m_st[p] <= 3; m_c[p] <= 0; m_t[p] <= 1'b0; end
                        2: if (w) begin m_st[p] <= 3; m_c[p] <= 0; m_t[p] <= 1'b1; end
                        default: begin
                            if (w != m_t[p]) begin
                                m_t[p] <= w; m_c[p] <= 0;
                            end else if (m_c[p] == DEAD - 1) begin
                                m_st[p] <= m_t[p] ? 1 : 2;
                            end else begin
                                m_c[p] <= m_c[p] + 1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [5:0] eg;
        int em;
        if (rst_n && !done) begin
            eg = {m_st[2] == 2, m_st[1] == 2, m_st[2] == 1, m_st[1] == 1, m_st[0] == 2, m_st[0] == 1};
            em = (m_mode < 0) ? 0 : m_mode;
            chk(gate == eg, "R9 gates", int'(gate), int'(eg));
            chk(int'(mode) == em, "R2 R3 R4 R5 mode", int'(mode), em);
            chk((gate[2] == gate[0]) && (gate[4] == gate[1]), "R7 mirror", int'(gate), int'(eg));
            chk(!(gate[0] && gate[1]) && !(gate[2] && gate[4]) && !(gate[3] && gate[5]),
                "R8 exclusive", int'(gate), int'(eg));
            if (m_mode >= 0) begin
                if (ref_prev > 0) chk(mode < 2'd2, "R6 positive family", int'(mode), 0);
                else              chk(mode >= 2'd2, "R6 negative family", int'(mode), 2);
            end
            if ((gate[0] ^ gate[1]) && (gate[2] ^ gate[4]) && (gate[3] ^ gate[5])) begin
                chk(gate == 6'b001101 || gate == 6'b011010 || gate == 6'b100101 || gate == 6'b110010,
                    "R10 legal row", int'(gate), 13);
            end
            ref_prev = m_ref;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle_check();
        en = 1'b0;
        @(negedge clk);
        chk(gate == 6'b0, "R1 gates idle", int'(gate), 0);
        chk(mode == 2'd0, "R1 mode idle", int'(mode), 0);
        run(3);
    endtask

    initial begin
        run(3);
        chk(gate == 6'b0, "R1 gates in reset", int'(gate), 0);
        chk(mode == 2'd0, "R1 mode in reset", int'(mode), 0);
        rst_n = 1'b1;
        run(2);
        // Full, half, low and zero modulation over whole reference periods
        ftw = 32'd2796203;
        mi = 8'd255; en = 1'b1; run(3200); idle_check();
        mi = 8'd128; en = 1'b1; run(3200); idle_check();
        mi = 8'd60;  en = 1'b1; run(1700); idle_check();
        mi = 8'd0;   en = 1'b1; run(400);  idle_check();
        // Fast phase, then an enable drop mid-period to restart at phase zero
        ftw = 32'h0200_0000;
        mi = 8'd250; en = 1'b1; run(777); idle_check();
        en = 1'b1; run(1000);
        mi = 8'd200; run(500); idle_check();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule